// File: doc/BRIEF.md
# Tag-Renaming Dynamic Scheduler with Shared Result Bus

This block is an out-of-order arithmetic scheduler. Instructions enter in program order through one issue port. Each one is placed in a free reservation station of the matching pool. The adder pool handles add, subtract and exclusive-or. The multiplier pool handles multiply. At issue, every source register is resolved to a value when one is available. Otherwise it becomes the tag of the station that will produce it. The destination register is then renamed to the tag of the new station. This renaming removes stalls caused by write-after-read and write-after-write conflicts.

A station starts its execution latency once both of its operand tags are zero. When the latency ends, the station requests the single result bus. That bus carries a 64-bit value and a 4-bit tag. Every waiting station and every register status entry compares the tag and takes the value on a match. If several stations are done in the same cycle, the one issued first takes the bus. The others keep their results and try again.

The architectural register file starts with register k holding the value k. A read port shows any register's current value and its pending tag.

Top module: `dyn_sched`

## Requirements
- R1: After reset, `iss_ready_o` is 1 for every op, `cdb_valid_o` is 0, and every register k reads value k with tag 0.
- R2: The op code selects the operation and the pool. 0 is add, 1 is subtract (src1 minus src2) and 3 is bitwise exclusive-or, all in the adder pool with tags 1 to 3. 2 is the low 64 bits of the product, in the multiplier pool with tags 4 to 5. The lowest-numbered free station of the pool is chosen.
- R3: `iss_ready_o` is 0 when the pool selected by `iss_op_i` has no free station. An issue request made while it is 0 changes no state.
- R4: On the edge that accepts an issue, the destination register's tag becomes the tag of the allocated station.
- R5: An instruction whose operands are all available at issue puts its result on the bus in the cycle after the LAT-th rising edge following the issue edge. LAT is 2 for the adder pool and 4 for the multiplier pool. The bus stays idle before that cycle when no other instruction is in flight.
- R6: Every broadcast carries the tag of an in-flight instruction. Its value equals that instruction's operation applied to its sources in program order.
- R7: A station with a pending operand tag captures the value from the bus on a tag match. It starts execution only after both tags are cleared.
- R8: At most one result is broadcast per cycle. Among stations done in the same cycle, the earliest issued wins, and a loser keeps its result for a later cycle.
- R9: A source whose producer broadcasts in the same cycle as the issue receives the bus value directly.
- R10: A register takes a bus value only while its tag equals the broadcast tag. After all instructions drain, every register holds the value from its last writer in program order and has tag 0.
- R11: A station becomes free on the edge that ends its broadcast, and its tag can then be issued again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| iss_valid_i | input | 1 | Issue request |
| iss_op_i | input | 2 | Operation code |
| iss_dst_i | input | 3 | Destination register |
| iss_src1_i | input | 3 | First source register |
| iss_src2_i | input | 3 | Second source register |
| iss_ready_o | output | 1 | Free station exists in the pool of `iss_op_i` |
| cdb_valid_o | output | 1 | Result bus carries a value |
| cdb_tag_o | output | 4 | Tag of the broadcasting station |
| cdb_data_o | output | 64 | Broadcast result |
| rd_addr_i | input | 3 | Register selected for the read port |
| rd_data_o | output | 64 | Value of the selected register |
| rd_tag_o | output | 4 | Pending producer tag of the selected register, 0 if none |

## Verification
If a station keeps a stale operand tag, it never starts. Its result never appears on the bus, and the run stalls one producer latency after the expected broadcast. If a station captures the wrong value, the error shows up in the data of its own broadcast, LAT cycles after the capture. If a register is overwritten by an older writer after a rename, the error stays hidden until the register is read after the drain. The read port is therefore checked on every issue (tag) and on every register at the end (value and tag). An arbitration fault changes the order of tags on the bus in the cycle where two stations finish together.

// File: rtl/dyn_sched_pkg.sv
`timescale 1ns/1ps
package dyn_sched_pkg;
  localparam int XLEN  = 64;
  localparam int TAG_W = 4;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_MUL = 2'b10,
    OP_XOR = 2'b11
  } op_e;

  function automatic logic [XLEN-1:0] alu(input op_e op, input logic [XLEN-1:0] a,
                                           input logic [XLEN-1:0] b);
    case (op)
      OP_ADD:  return a + b;
      OP_SUB:  return a - b;
      OP_XOR:  return a ^ b;
      default: return a * b;
    endcase
  endfunction
endpackage

// File: rtl/rs_entry.sv
`timescale 1ns/1ps
module rs_entry import dyn_sched_pkg::*; #(
  parameter int SEQ_W = 5,
  parameter int LAT   = 2,
  localparam int CNT_W = $clog2(LAT) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  op_e              op_i,
  input  logic [XLEN-1:0]  vj_i,
  input  logic [XLEN-1:0]  vk_i,
  input  logic [TAG_W-1:0] qj_i,
  input  logic [TAG_W-1:0] qk_i,
  input  logic [SEQ_W-1:0] seq_i,
  input  logic             cdb_valid_i,
  input  logic [TAG_W-1:0] cdb_tag_i,
  input  logic [XLEN-1:0]  cdb_data_i,
  input  logic             grant_i,
  output logic             busy_o,
  output logic             req_o,
  output logic [XLEN-1:0]  result_o,
  output logic [SEQ_W-1:0] seq_o
);
  logic             busy_q, started_q;
  op_e              op_q;
  logic [XLEN-1:0]  vj_q, vk_q, res_q;
  logic [TAG_W-1:0] qj_q, qk_q;
  logic [SEQ_W-1:0] seq_q;
  logic [CNT_W-1:0] cnt_q;

  logic ops_ready, hit_j, hit_k;
  assign ops_ready = (qj_q == '0) && (qk_q == '0);
  assign hit_j     = cdb_valid_i && (qj_q != '0) && (cdb_tag_i == qj_q);
  assign hit_k     = cdb_valid_i && (qk_q != '0) && (cdb_tag_i == qk_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      started_q <= 1'b0;
      op_q      <= OP_ADD;
      vj_q      <= '0;
      vk_q      <= '0;
      res_q     <= '0;
      qj_q      <= '0;
      qk_q      <= '0;
      seq_q     <= '0;
      cnt_q     <= '0;
    end else if (alloc_i) begin
      busy_q    <= 1'b1;
      started_q <= 1'b0;
      op_q      <= op_i;
      vj_q      <= vj_i;
      vk_q      <= vk_i;
      qj_q      <= qj_i;
      qk_q      <= qk_i;
      seq_q     <= seq_i;
      cnt_q     <= '0;
    end else if (busy_q) begin
      if (grant_i) begin
        busy_q    <= 1'b0;
        started_q <= 1'b0;
      end else begin
        if (hit_j) begin
          vj_q <= cdb_data_i;
          qj_q <= '0;
        end
        if (hit_k) begin
          vk_q <= cdb_data_i;
          qk_q <= '0;
        end
        if (!started_q && ops_ready) begin
          started_q <= 1'b1;
          cnt_q     <= CNT_W'(LAT - 1);
          res_q     <= alu(op_q, vj_q, vk_q);
        end else if (started_q && cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign busy_o   = busy_q;
  assign req_o    = busy_q && started_q && (cnt_q == '0);
  assign result_o = res_q;
  assign seq_o    = seq_q;

  // R7
  start_needs_operands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(started_q) |-> $past(qj_q == '0 && qk_q == '0));
  // R8
  loser_holds_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !grant_i) |=> (req_o && $stable(res_q)));
  // R11
  free_after_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(grant_i));
endmodule

// File: rtl/cdb_arb.sv
`timescale 1ns/1ps
module cdb_arb import dyn_sched_pkg::*; #(
  parameter int N     = 5,
  parameter int SEQ_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     req_i,
  input  logic [SEQ_W-1:0] seq_i [N],
  input  logic [SEQ_W-1:0] head_i,
  output logic [N-1:0]     grant_o,
  output logic             valid_o,
  output logic [TAG_W-1:0] tag_o
);
  logic [SEQ_W-1:0] age, best_age;
  logic             found;

  // age relative to the next sequence number; larger means issued earlier
  always_comb begin
    grant_o  = '0;
    found    = 1'b0;
    best_age = '0;
    tag_o    = '0;
    age      = '0;
    for (int i = 0; i < N; i++) begin
      age = head_i - seq_i[i];
      if (req_i[i] && (!found || age > best_age)) begin
        found    = 1'b1;
        best_age = age;
        grant_o  = '0;
        grant_o[i] = 1'b1;
        tag_o    = TAG_W'(i + 1);
      end
    end
  end
  assign valid_o = found;

  // R8
  single_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));
  // R8
  grant_to_requester_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o & ~req_i) == '0);
endmodule

// File: rtl/reg_status.sv
`timescale 1ns/1ps
module reg_status import dyn_sched_pkg::*; #(
  parameter int NREG = 8,
  localparam int REG_W = $clog2(NREG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rn_valid_i,
  input  logic [REG_W-1:0] rn_reg_i,
  input  logic [TAG_W-1:0] rn_tag_i,
  input  logic             cdb_valid_i,
  input  logic [TAG_W-1:0] cdb_tag_i,
  input  logic [XLEN-1:0]  cdb_data_i,
  input  logic [REG_W-1:0] a_addr_i,
  output logic [XLEN-1:0]  a_data_o,
  output logic [TAG_W-1:0] a_tag_o,
  input  logic [REG_W-1:0] b_addr_i,
  output logic [XLEN-1:0]  b_data_o,
  output logic [TAG_W-1:0] b_tag_o,
  input  logic [REG_W-1:0] c_addr_i,
  output logic [XLEN-1:0]  c_data_o,
  output logic [TAG_W-1:0] c_tag_o
);
  logic [XLEN-1:0]  rf_q   [NREG];
  logic [TAG_W-1:0] stat_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NREG; r++) begin
        rf_q[r]   <= XLEN'(r);
        stat_q[r] <= '0;
      end
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (cdb_valid_i && stat_q[r] != '0 && stat_q[r] == cdb_tag_i) begin
          rf_q[r] <= cdb_data_i;
          if (!(rn_valid_i && rn_reg_i == REG_W'(r))) stat_q[r] <= '0;
        end
        if (rn_valid_i && rn_reg_i == REG_W'(r)) stat_q[r] <= rn_tag_i;
      end
    end
  end

  assign a_data_o = rf_q[a_addr_i];
  assign a_tag_o  = stat_q[a_addr_i];
  assign b_data_o = rf_q[b_addr_i];
  assign b_tag_o  = stat_q[b_addr_i];
  assign c_data_o = rf_q[c_addr_i];
  assign c_tag_o  = stat_q[c_addr_i];

  for (genvar g = 0; g < NREG; g++) begin : g_chk
    // R4
    rename_sets_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rn_valid_i && rn_reg_i == REG_W'(g)) |=> stat_q[g] == $past(rn_tag_i));
    // R10
    pending_tag_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_q[g] != '0 && !(cdb_valid_i && cdb_tag_i == stat_q[g])) |=> stat_q[g] != '0);
    // R10
    value_guarded_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(cdb_valid_i && stat_q[g] != '0 && cdb_tag_i == stat_q[g]) |=> $stable(rf_q[g]));
  end
endmodule

// File: rtl/dyn_sched.sv
`timescale 1ns/1ps
module dyn_sched import dyn_sched_pkg::*; #(
  parameter int N_ADD   = 3,
  parameter int N_MUL   = 2,
  parameter int NREG    = 8,
  parameter int ADD_LAT = 2,
  parameter int MUL_LAT = 4,
  localparam int REG_W  = $clog2(NREG),
  localparam int N_RS   = N_ADD + N_MUL,
  localparam int SEQ_W  = $clog2(N_RS) + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             iss_valid_i,
  input  logic [1:0]       iss_op_i,
  input  logic [REG_W-1:0] iss_dst_i,
  input  logic [REG_W-1:0] iss_src1_i,
  input  logic [REG_W-1:0] iss_src2_i,
  output logic             iss_ready_o,
  output logic             cdb_valid_o,
  output logic [TAG_W-1:0] cdb_tag_o,
  output logic [XLEN-1:0]  cdb_data_o,
  input  logic [REG_W-1:0] rd_addr_i,
  output logic [XLEN-1:0]  rd_data_o,
  output logic [TAG_W-1:0] rd_tag_o
);
  logic [N_RS-1:0]  busy, req, grant, alloc, pick_oh;
  logic [XLEN-1:0]  res [N_RS];
  logic [SEQ_W-1:0] seq [N_RS];
  logic [SEQ_W-1:0] head_q;
  logic             pick_ok, pool_mul, iss_fire;
  logic [TAG_W-1:0] pick_tag;
  logic             cdb_valid;
  logic [TAG_W-1:0] cdb_tag;
  logic [XLEN-1:0]  cdb_data;

  logic [XLEN-1:0]  a_val, b_val, vj, vk;
  logic [TAG_W-1:0] a_tag, b_tag, qj, qk;

  assign pool_mul = (op_e'(iss_op_i) == OP_MUL);

  always_comb begin
    pick_ok  = 1'b0;
    pick_oh  = '0;
    pick_tag = '0;
    for (int i = 0; i < N_RS; i++) begin
      if (!pick_ok && !busy[i] && ((i >= N_ADD) == pool_mul)) begin
        pick_ok    = 1'b1;
        pick_oh[i] = 1'b1;
        pick_tag   = TAG_W'(i + 1);
      end
    end
  end

  assign iss_ready_o = pick_ok;
  assign iss_fire    = iss_valid_i && pick_ok;
  assign alloc       = iss_fire ? pick_oh : '0;

  // source resolution with same-cycle bus forwarding
  always_comb begin
    vj = a_val;
    qj = a_tag;
    if (a_tag != '0) begin
      if (cdb_valid && cdb_tag == a_tag) begin
        vj = cdb_data;
        qj = '0;
      end else begin
        vj = '0;
      end
    end
    vk = b_val;
    qk = b_tag;
    if (b_tag != '0) begin
      if (cdb_valid && cdb_tag == b_tag) begin
        vk = cdb_data;
        qk = '0;
      end else begin
        vk = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       head_q <= '0;
    else if (iss_fire) head_q <= head_q + 1'b1;
  end

  for (genvar g = 0; g < N_RS; g++) begin : g_rs
    localparam int LAT = (g < N_ADD) ? ADD_LAT : MUL_LAT;
    rs_entry #(.SEQ_W(SEQ_W), .LAT(LAT)) u_rs (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .alloc_i     (alloc[g]),
      .op_i        (op_e'(iss_op_i)),
      .vj_i        (vj),
      .vk_i        (vk),
      .qj_i        (qj),
      .qk_i        (qk),
      .seq_i       (head_q),
      .cdb_valid_i (cdb_valid),
      .cdb_tag_i   (cdb_tag),
      .cdb_data_i  (cdb_data),
      .grant_i     (grant[g]),
      .busy_o      (busy[g]),
      .req_o       (req[g]),
      .result_o    (res[g]),
      .seq_o       (seq[g])
    );
  end

  cdb_arb #(.N(N_RS), .SEQ_W(SEQ_W)) u_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req),
    .seq_i   (seq),
    .head_i  (head_q),
    .grant_o (grant),
    .valid_o (cdb_valid),
    .tag_o   (cdb_tag)
  );

  always_comb begin
    cdb_data = '0;
    for (int i = 0; i < N_RS; i++)
      if (grant[i]) cdb_data = cdb_data | res[i];
  end

  reg_status #(.NREG(NREG)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rn_valid_i  (iss_fire),
    .rn_reg_i    (iss_dst_i),
    .rn_tag_i    (pick_tag),
    .cdb_valid_i (cdb_valid),
    .cdb_tag_i   (cdb_tag),
    .cdb_data_i  (cdb_data),
    .a_addr_i    (iss_src1_i),
    .a_data_o    (a_val),
    .a_tag_o     (a_tag),
    .b_addr_i    (iss_src2_i),
    .b_data_o    (b_val),
    .b_tag_o     (b_tag),
    .c_addr_i    (rd_addr_i),
    .c_data_o    (rd_data_o),
    .c_tag_o     (rd_tag_o)
  );

  assign cdb_valid_o = cdb_valid;
  assign cdb_tag_o   = cdb_tag;
  assign cdb_data_o  = cdb_data;

  // R6
  bus_tag_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cdb_valid_o |-> (cdb_tag_o != '0 && cdb_tag_o <= TAG_W'(N_RS)));
  // R11
  no_alloc_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc & busy) == '0);
endmodule

// File: tb/dyn_sched_bench.sv
`timescale 1ns/1ps
module dyn_sched_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iss_valid = 1'b0;
  logic [1:0]  iss_op = 2'd0;
  logic [2:0]  iss_dst = 3'd0, iss_s1 = 3'd0, iss_s2 = 3'd0, rd_addr = 3'd0;
  logic        iss_ready, cdb_valid;
  logic [3:0]  cdb_tag, rd_tag;
  logic [63:0] cdb_data, rd_data;

  int checks = 0, fails = 0;
  logic [63:0] ref_reg [8];
  logic [63:0] exp_val [16];
  bit          pend [16];
  int          pend_cnt = 0;
  int          last_tag = 0;

  always #2.5 clk = ~clk;

  dyn_sched u_dyn_sched (
    .clk_i(clk), .rst_ni(rst_n), .iss_valid_i(iss_valid), .iss_op_i(iss_op),
    .iss_dst_i(iss_dst), .iss_src1_i(iss_s1), .iss_src2_i(iss_s2),
    .iss_ready_o(iss_ready), .cdb_valid_o(cdb_valid), .cdb_tag_o(cdb_tag),
    .cdb_data_o(cdb_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .rd_tag_o(rd_tag)
  );

  function automatic logic [63:0] ref_alu(input logic [1:0] op, input logic [63:0] a,
                                           input logic [63:0] b);
    case (op)
      2'd0: return a + b;
      2'd1: return a - b;
      2'd3: return a ^ b;
      default: return a * b;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // bus monitor: every broadcast must belong to an in-flight instruction (R6, R8)
  always @(negedge clk) begin
    if (rst_n && cdb_valid) begin
      if (!pend[cdb_tag]) begin
        chk(1'b0, "R6", "unexpected bus tag", 64'(cdb_tag), 64'd0);
      end else begin
        chk(cdb_data === exp_val[cdb_tag], "R6", "bus data", cdb_data, exp_val[cdb_tag]);
        pend[cdb_tag] = 1'b0;
        pend_cnt--;
      end
    end
  end

  task automatic issue(input logic [1:0] op, input int d, input int s1, input int s2);
    logic [63:0] v;
    bit in_pool;
    iss_valid = 1'b1;
    iss_op    = op;
    iss_dst   = 3'(d);
    iss_s1    = 3'(s1);
    iss_s2    = 3'(s2);
    #1;
    while (!iss_ready) begin
      tick();
      #1;
    end
    tick();
    iss_valid = 1'b0;
    v = ref_alu(op, ref_reg[s1], ref_reg[s2]);
    ref_reg[d] = v;
    rd_addr = 3'(d);
    #1;
    last_tag = int'(rd_tag);
    in_pool = (op == 2'd2) ? (rd_tag >= 4 && rd_tag <= 5) : (rd_tag >= 1 && rd_tag <= 3);
    chk(in_pool, "R4", "renamed tag in pool", 64'(rd_tag), 64'(op));
    exp_val[rd_tag] = v;
    pend[rd_tag] = 1'b1;
    pend_cnt++;
  endtask

  task automatic drain();
    int n = 0;
    while (pend_cnt != 0 && n < 500) begin
      tick();
      n++;
    end
    chk(pend_cnt == 0, "R7", "all waiting stations completed", 64'(pend_cnt), 64'd0);
    tick();
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL R5 watchdog expired act=1 exp=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int mul_tag, add_tag;
    void'($urandom(32'd20240611));
    for (int r = 0; r < 8; r++) ref_reg[r] = 64'(r);
    for (int t = 0; t < 16; t++) begin
      pend[t] = 1'b0;
      exp_val[t] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(iss_ready == 1'b1, "R1", "ready after reset", 64'(iss_ready), 64'd1);
    chk(cdb_valid == 1'b0, "R1", "bus idle after reset", 64'(cdb_valid), 64'd0);
    for (int r = 0; r < 8; r++) begin
      rd_addr = 3'(r);
      #1;
      chk(rd_data == 64'(r) && rd_tag == 4'd0, "R1", "reset register", rd_data, 64'(r));
    end
    iss_op = 2'd2;
    #1;
    chk(iss_ready == 1'b1, "R1", "mul ready after reset", 64'(iss_ready), 64'd1);
    @(negedge clk);

    // R2/R5 lone add: tag 1, latency 2
    issue(2'd0, 1, 2, 3);
    chk(last_tag == 1, "R2", "first add tag", 64'(last_tag), 64'd1);
    tick();
    chk(cdb_valid == 1'b0, "R5", "no early broadcast", 64'(cdb_valid), 64'd0);
    tick();
    chk(cdb_valid && cdb_tag == 4'd1, "R5", "add broadcast at latency", 64'(cdb_tag), 64'd1);
    drain();
    rd_addr = 3'd1;
    #1;
    chk(rd_data == 64'd5 && rd_tag == 4'd0, "R2", "add writes 2+3", rd_data, 64'd5);

    // R8 contention: mul then add finishing in the same cycle
    issue(2'd2, 4, 2, 3);
    mul_tag = last_tag;
    chk(mul_tag == 4, "R2", "first mul tag", 64'(mul_tag), 64'd4);
    tick();
    issue(2'd1, 5, 1, 2);
    add_tag = last_tag;
    tick();
    tick();
    chk(cdb_valid && cdb_tag == 4'(mul_tag), "R8", "older wins bus", 64'(cdb_tag), 64'(mul_tag));
    tick();
    chk(cdb_valid && cdb_tag == 4'(add_tag), "R8", "loser next cycle", 64'(cdb_tag), 64'(add_tag));
    drain();

    // R9 issue in the same cycle as the producer broadcasts
    issue(2'd2, 6, 4, 4);
    mul_tag = last_tag;
    tick(); tick(); tick(); tick();
    chk(cdb_valid && cdb_tag == 4'(mul_tag), "R9", "producer on bus", 64'(cdb_tag), 64'(mul_tag));
    issue(2'd0, 7, 6, 1);
    add_tag = last_tag;
    tick();
    tick();
    chk(cdb_valid && cdb_tag == 4'(add_tag), "R9", "forwarded consumer runs", 64'(cdb_tag), 64'(add_tag));
    drain();

    // R3 full adder pool, R11 freed after broadcast
    issue(2'd2, 1, 2, 3);
    issue(2'd0, 4, 1, 1);
    issue(2'd3, 4, 1, 2);
    issue(2'd1, 5, 1, 0);
    iss_op = 2'd0;
    #1;
    chk(iss_ready == 1'b0, "R3", "adder pool full", 64'(iss_ready), 64'd0);
    iss_op = 2'd2;
    #1;
    chk(iss_ready == 1'b1, "R3", "mul pool still free", 64'(iss_ready), 64'd1);
    iss_op = 2'd0;
    iss_dst = 3'd6;
    iss_s1 = 3'd0;
    iss_s2 = 3'd0;
    iss_valid = 1'b1;
    tick();
    iss_valid = 1'b0;
    rd_addr = 3'd6;
    #1;
    chk(rd_tag == 4'd0, "R3", "stalled request no rename", 64'(rd_tag), 64'd0);
    drain();
    iss_op = 2'd0;
    #1;
    chk(iss_ready == 1'b1, "R11", "stations freed", 64'(iss_ready), 64'd1);

    // R10 write-after-write: slow older writer must not overwrite
    issue(2'd2, 3, 2, 2);
    issue(2'd0, 3, 1, 1);
    drain();
    rd_addr = 3'd3;
    #1;
    chk(rd_data == ref_reg[3] && rd_tag == 4'd0, "R10", "last writer kept", rd_data, ref_reg[3]);

    // random traffic (R6, R7, R8, R10)
    for (int k = 0; k < 300; k++) begin
      issue(2'($urandom % 4), int'($urandom % 8), int'($urandom % 8), int'($urandom % 8));
      repeat ($urandom % 3) tick();
    end
    drain();
    for (int r = 0; r < 8; r++) begin
      rd_addr = 3'(r);
      #1;
      chk(rd_data == ref_reg[r], "R10", "final register value", rd_data, ref_reg[r]);
      chk(rd_tag == 4'd0, "R10", "final register tag", 64'(rd_tag), 64'd0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule